// File: doc/BRIEF.md
# Two-Digit Decimal Cascade Counter

This block counts clock cycles from 00 to 99 in decimal and starts again at 00. It is built from identical four-bit BCD digit stages that all share one clock. Each stage has a step enable and a wrap strobe. The strobe fires in the cycle where that stage goes from 9 back to 0. The lowest stage steps on every clock. Each higher stage steps only in a cycle where the stage below it wraps. No adder computes the next value. Instead, each bit has its own toggle condition built from the current digit bits.

The wrap strobes are also outputs. The low strobe gives one pulse every ten clocks and the high strobe gives one pulse every hundred clocks, so they can serve as divide-by-10 and divide-by-100 ticks. A parameter sets the code that reset loads. The default is all zeros. A stage that holds a non-decimal code (10 to 15) returns to the decimal sequence within two of its own steps.

Top module: `decadeCascade`

## Requirements
- R1: While `rst` is high at a rising clock edge, every stage loads its reset code from `INIT_CODE`, which defaults to zero. The low digit is `countOut[3:0]` and the high digit is `countOut[7:4]`.
- R2: With `rst` low, the low digit advances by one on every clock, and goes from 9 to 0.
- R3: The high digit changes only on a clock where the low digit wraps. At that clock it advances by one, and goes from 9 to 0. On every other clock it holds its value.
- R4: `stageTick[0]` is high exactly while the low digit is 9. After the reset code is zero, it pulses for one cycle in every 10.
- R5: `stageTick[1]` is high exactly while both digits are 9. From a zero reset code, it pulses for one cycle in every 100.
- R6: From a zero reset code, `countOut` read as two BCD digits equals the number of clocks since reset, modulo 100.
- R7: A stage holding a non-decimal code steps as follows: 10→11→6, 12→13→4, 14→15→2. It reaches 0 to 9 within two of its steps, and it never asserts its wrap strobe while holding such a code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all stages |
| rst | input | 1 | Synchronous reset, active high |
| countOut | output | 4*NUM_DIGITS | BCD digits, with the low digit in the least significant nibble |
| stageTick | output | NUM_DIGITS | Wrap strobe of each stage, with bit 0 for the low stage |

## Verification
The assertions assume that once `rst` is released it stays low for long enough to watch a full step or a two-step recovery. They also assume that `INIT_CODE` is the only source of non-decimal codes. The bench releases reset once and pulses it once more at a random cycle taken from a fixed seed. It then lets every instance run freely for hundreds of clocks, so the windows the properties look at always follow a clean reset. Three instances cover the zero reset code and the non-decimal codes 10, 12, 14 and 15 across both stages.

// File: rtl/decadePkg.sv
package decadePkg;
  typedef logic [3:0] bcd_t;

  localparam bcd_t TOP_CODE = 4'd9;

  typedef struct packed {
    logic stepEn;
    logic wrapNow;
  } digitStrobe_t;
endpackage

// File: rtl/decadeDigit.sv
module decadeDigit
  import decadePkg::*;
#(
  parameter bcd_t RESET_CODE = 4'd0
) (
  input  logic clk,
  input  logic rst,
  input  logic stepEn,
  output bcd_t code,
  output logic atNine
);
  bcd_t toggleMask;

  always_comb begin
    toggleMask[0] = 1'b1;
    toggleMask[1] = ~code[3] & code[0];
    toggleMask[2] = code[1] & code[0];
    toggleMask[3] = (code[2] & code[1] & code[0]) | (code[3] & code[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) code <= RESET_CODE;
    else     code <= code ^ (toggleMask & {4{stepEn}});
  end

  assign atNine = (code == TOP_CODE);
endmodule

// File: rtl/decadeDatapath.sv
module decadeDatapath
  import decadePkg::*;
#(
  parameter int NUM_DIGITS = 2,
  parameter logic [4*NUM_DIGITS-1:0] INIT_CODE = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  digitStrobe_t [NUM_DIGITS-1:0] strobes,
  output logic [4*NUM_DIGITS-1:0]       codes,
  output logic [NUM_DIGITS-1:0]         atNine
);
  for (genvar d = 0; d < NUM_DIGITS; d++) begin : gDigit
    bcd_t digitCode;
    decadeDigit #(.RESET_CODE(INIT_CODE[4*d +: 4])) uDigit (
      .clk   (clk),
      .rst   (rst),
      .stepEn(strobes[d].stepEn),
      .code  (digitCode),
      .atNine(atNine[d])
    );
    assign codes[4*d +: 4] = digitCode;
  end
endmodule

// File: rtl/decadeControl.sv
module decadeControl
  import decadePkg::*;
#(
  parameter int NUM_DIGITS = 2
) (
  input  logic [NUM_DIGITS-1:0]         atNine,
  output digitStrobe_t [NUM_DIGITS-1:0] strobes,
  output logic [NUM_DIGITS-1:0]         ticks
);
  for (genvar d = 0; d < NUM_DIGITS; d++) begin : gChain
    if (d == 0) begin : gFirst
      assign strobes[d].stepEn = 1'b1;
    end else begin : gNext
      assign strobes[d].stepEn = strobes[d-1].wrapNow;
    end
    assign strobes[d].wrapNow = strobes[d].stepEn & atNine[d];
    assign ticks[d] = strobes[d].wrapNow;
  end
endmodule

// File: rtl/decadeCascade.sv
module decadeCascade
  import decadePkg::*;
#(
  parameter int NUM_DIGITS = 2,
  parameter logic [4*NUM_DIGITS-1:0] INIT_CODE = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [4*NUM_DIGITS-1:0] countOut,
  output logic [NUM_DIGITS-1:0]   stageTick
);
  digitStrobe_t [NUM_DIGITS-1:0] strobes;
  logic [NUM_DIGITS-1:0]         atNine;

  decadeControl #(.NUM_DIGITS(NUM_DIGITS)) uCtl (
    .atNine (atNine),
    .strobes(strobes),
    .ticks  (stageTick)
  );

  decadeDatapath #(.NUM_DIGITS(NUM_DIGITS), .INIT_CODE(INIT_CODE)) uPath (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .codes  (countOut),
    .atNine (atNine)
  );
endmodule

// File: rtl/decadeCascadeChk.sv
module decadeCascadeChk #(
  parameter int NUM_DIGITS = 2,
  parameter logic [4*NUM_DIGITS-1:0] INIT_CODE = '0
) (
  input logic                    clk,
  input logic                    rst,
  input logic [4*NUM_DIGITS-1:0] countOut,
  input logic [NUM_DIGITS-1:0]   stageTick
);
  logic [3:0] lowDigit;
  assign lowDigit = countOut[3:0];

  AST_RESET_LOAD: assert property (@(posedge clk) rst |=> countOut == INIT_CODE); // R1
  AST_LOW_STEP: assert property (@(posedge clk) disable iff (rst)
    (lowDigit <= 4'd8) |=> (lowDigit == $past(lowDigit) + 4'd1)); // R2
  AST_LOW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (lowDigit == 4'd9) |=> (lowDigit == 4'd0)); // R2
  AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (rst)
    stageTick[0] |=> (lowDigit == 4'd0)); // R4
  AST_RECOVER: assert property (@(posedge clk) disable iff (rst)
    (lowDigit > 4'd9) |-> ##2 (lowDigit <= 4'd9)); // R7
  AST_NO_TICK_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (lowDigit > 4'd9) |-> !stageTick[0]); // R7

  if (NUM_DIGITS >= 2) begin : gHigh
    logic [3:0] highDigit;
    assign highDigit = countOut[7:4];
    AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
      !stageTick[0] |=> $stable(highDigit)); // R3
    AST_BOTH_WRAP: assert property (@(posedge clk) disable iff (rst)
      stageTick[1] |=> (countOut[7:0] == 8'h00)); // R5
  end
endmodule

bind decadeCascade decadeCascadeChk #(.NUM_DIGITS(NUM_DIGITS), .INIT_CODE(INIT_CODE)) uChk (
  .clk      (clk),
  .rst      (rst),
  .countOut (countOut),
  .stageTick(stageTick)
);

// File: tb/sim_decadeCascade.sv
module sim_decadeCascade;
  localparam int CLK_NS = 10;
  localparam logic [7:0] INIT_A = 8'h00;
  localparam logic [7:0] INIT_B = 8'hCA;
  localparam logic [7:0] INIT_C = 8'hFE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cnt0, cnt1, cnt2;
  logic [1:0] tk0, tk1, tk2;
  int total = 0;
  int bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  decadeCascade u0 (.clk(clk), .rst(rst), .countOut(cnt0), .stageTick(tk0));
  decadeCascade #(.INIT_CODE(INIT_B)) u1 (.clk(clk), .rst(rst), .countOut(cnt1), .stageTick(tk1));
  decadeCascade #(.INIT_CODE(INIT_C)) u2 (.clk(clk), .rst(rst), .countOut(cnt2), .stageTick(tk2));

  function automatic logic [3:0] nextCode(input logic [3:0] q);
    case (q)
      4'd9:    return 4'd0;
      4'd10:   return 4'd11;
      4'd11:   return 4'd6;
      4'd12:   return 4'd13;
      4'd13:   return 4'd4;
      4'd14:   return 4'd15;
      4'd15:   return 4'd2;
      default: return q + 4'd1;
    endcase
  endfunction

  function automatic logic [7:0] nextPair(input logic [7:0] p);
    logic [3:0] hi;
    hi = (p[3:0] == 4'd9) ? nextCode(p[7:4]) : p[7:4];
    return {hi, nextCode(p[3:0])};
  endfunction

  function automatic logic [1:0] ticksOf(input logic [7:0] p);
    return {(p == 8'h99), (p[3:0] == 4'd9)};
  endfunction

  logic [7:0] m0, m1, m2;
  always @(posedge clk) begin
    if (rst) begin
      m0 <= INIT_A; m1 <= INIT_B; m2 <= INIT_C;
    end else begin
      m0 <= nextPair(m0); m1 <= nextPair(m1); m2 <= nextPair(m2);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int resetAt;
    int resetLen;
    int last0;
    int last1;
    int ticks100;
    void'($urandom(32'd4242));
    resetAt  = 60 + int'($urandom % 30);
    resetLen = 1 + int'($urandom % 3);
    last0 = -1;
    last1 = -1;
    ticks100 = 0;
    repeat (3) @(negedge clk);
    check("R1 u0 reset", int'(cnt0), int'(INIT_A));
    check("R1 u1 reset", int'(cnt1), int'(INIT_B));
    check("R1 u2 reset", int'(cnt2), int'(INIT_C));
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R7 10 then 11 then 6", int'(cnt1[3:0]), 6);
    check("R7 14 then 15 then 2", int'(cnt2[3:0]), 2);
    check("R7 high code held", int'(cnt1[7:4]), 12);
    for (int cyc = 0; cyc < 420; cyc++) begin
      if (cyc == resetAt) rst = 1'b1;
      if (cyc == resetAt + resetLen) rst = 1'b0;
      @(negedge clk);
      check("R6 u0 count", int'(cnt0), int'(m0));
      check("R2 R3 R7 u1 count", int'(cnt1), int'(m1));
      check("R2 R3 R7 u2 count", int'(cnt2), int'(m2));
      check("R4 R5 u0 ticks", int'(tk0), int'(ticksOf(m0)));
      check("R4 R5 R7 u1 ticks", int'(tk1), int'(ticksOf(m1)));
      check("R4 R5 R7 u2 ticks", int'(tk2), int'(ticksOf(m2)));
      if (rst) begin
        last0 = -1;
        last1 = -1;
        check("R1 u0 reload", int'(cnt0), 0);
      end else begin
        if (tk0[0]) begin
          if (last0 >= 0) check("R4 period 10", cyc - last0, 10);
          last0 = cyc;
        end
        if (tk0[1]) begin
          if (last1 >= 0) check("R5 period 100", cyc - last1, 100);
          last1 = cyc;
          ticks100++;
        end
      end
    end
    check("R5 tick100 count", ticks100, 3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule